// File: doc/BRIEF.md
# Hashed Binary Tree Walk Engine

This engine moves a batch of walkers through a perfect binary tree over a configured number of rounds. The tree is a flat array of 32-bit node words in an internal RAM: node `k` has children `2k+1` and `2k+2`. Each walker keeps a node position and a 32-bit word, and every walker starts a run at the root. On each visit the walker's word is combined with the word of the node it stands on. The result is passed through a six-step integer mix. The low bit of the mixed word then picks the child the walker moves to next. A walker that steps past the last leaf goes back to the root.

Before a run, a host fills the node RAM and the walker word RAM through write ports. It then pulses `start` with the round count, the batch size and the tree height. The engine issues one walker per cycle into a pipeline that holds up to six mix stages. It writes results back in walker order and lets a round finish completely before the next round begins. When the last result is written it pulses `done`. While idle, the host reads each walker's final position and word through a registered read port.

Top module: `tw_walk_top`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: In the first round every walker reads node 0. In each step the walker's word becomes M(word XOR node[pos]). M applies six steps in order to a 32-bit word `a`, all modulo 2^32: (a+0x7ED55D16)+(a<<12); (a^0xC761C23C)^(a>>19); (a+0x165667B1)+(a<<5); (a+0xD3A2646C)^(a<<9); (a+0xFD7046C5)+(a<<3); (a^0xB55A4F09)^(a>>16).
- R3: The next position is 2*pos+1 when the new word is even (bit 0 = 0) and 2*pos+2 when it is odd.
- R4: With height h, a next position at or above 2^(h+1)-1 is replaced by 0.
- R5: The rounds run one after another, and each walker's position and word carry from one round into the next.
- R6: Within a round, write-backs occur in walker order 0..batch-1. Every walker of a round is written back before any walker of the next round is read, so a batch of one still sees its own previous result.
- R7: `done` is high for exactly one cycle after the final write-back, `busy` is low in that cycle, and `busy` is high from the cycle after an accepted `start` until then.
- R8: A start with zero rounds or zero batch size produces the `done` pulse and leaves every walker's position and word unchanged.
- R9: While `busy` is high, node writes, word writes and further `start` pulses are ignored.
- R10: While idle, `rd_pos` and `rd_word` show walker `rd_addr`'s position and word one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_we | input | 1 | Node RAM write strobe (idle only) |
| node_waddr | input | MAX_H+1 | Node RAM write address |
| node_wdata | input | 32 | Node word to write |
| word_we | input | 1 | Walker word write strobe (idle only) |
| word_waddr | input | WALK_AW | Walker to initialise |
| word_wdata | input | 32 | Initial walker word |
| start | input | 1 | Begin a run with the cfg_* values |
| cfg_rounds | input | ROUND_W | Number of rounds |
| cfg_batch | input | WALK_AW+1 | Number of walkers, 0..2^WALK_AW |
| cfg_height | input | clog2(MAX_H+1) | Tree height h, at most MAX_H |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_addr | input | WALK_AW | Walker to read back |
| rd_pos | output | MAX_H+1 | Walker position, one cycle after rd_addr |
| rd_word | output | 32 | Walker word, one cycle after rd_addr |

## Verification
The bench targets the cases where a pipelined walker could read stale state. A batch of one over several rounds would produce a wrong second-round result if the round barrier were missing, because the walker would read its position before its own write-back landed. Runs on trees of height 2 and 5 over many rounds force walkers to wrap past the leaves; a wrong bound would leave out-of-range positions or send walkers back to the root too early. A run with zero rounds and one with zero batch check that no walker's word or position changes. Writes and a second start issued mid-run check that a busy engine does not corrupt the node or word stores or restart.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int HASH_STAGES = 6;
  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DRAIN, ST_FIN} walk_st_e;

  // one step of the six-step word mix; k selects the step
  function automatic word_t mix_step(input int k, input word_t a);
    word_t r;
    case (k)
      0:       r = (a + 32'h7ED55D16) + (a << 12);
      1:       r = (a ^ 32'hC761C23C) ^ (a >> 19);
      2:       r = (a + 32'h165667B1) + (a << 5);
      3:       r = (a + 32'hD3A2646C) ^ (a << 9);
      4:       r = (a + 32'hFD7046C5) + (a << 3);
      default: r = (a ^ 32'hB55A4F09) ^ (a >> 16);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tw_ram.sv
module tw_ram #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tw_hash_pipe.sv
module tw_hash_pipe #(
  parameter int TAG_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_v,
  input  logic [TAG_W-1:0]  in_tag,
  input  tw_pkg::word_t     in_word,
  output logic              out_v,
  output logic [TAG_W-1:0]  out_tag,
  output tw_pkg::word_t     out_word
);
  import tw_pkg::*;

  logic [HASH_STAGES-1:0] v_q;
  word_t                  w_q [HASH_STAGES];
  logic [TAG_W-1:0]       t_q [HASH_STAGES];

  always_ff @(posedge clk) begin
    if (rst) v_q <= '0;
    else     v_q <= {v_q[HASH_STAGES-2:0], in_v};
  end

  always_ff @(posedge clk) begin
    w_q[0] <= mix_step(0, in_word);
    t_q[0] <= in_tag;
    for (int k = 1; k < HASH_STAGES; k++) begin
      w_q[k] <= mix_step(k, w_q[k-1]);
      t_q[k] <= t_q[k-1];
    end
  end

  assign out_v    = v_q[HASH_STAGES-1];
  assign out_tag  = t_q[HASH_STAGES-1];
  assign out_word = w_q[HASH_STAGES-1];
endmodule

// File: rtl/tw_walk_top.sv
module tw_walk_top #(
  parameter int MAX_H   = 5,
  parameter int WALK_AW = 4,
  parameter int ROUND_W = 8,
  localparam int NODE_AW = MAX_H + 1,
  localparam int HGT_W   = $clog2(MAX_H + 1),
  localparam int BATCH_W = WALK_AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               node_we,
  input  logic [NODE_AW-1:0] node_waddr,
  input  logic [31:0]        node_wdata,
  input  logic               word_we,
  input  logic [WALK_AW-1:0] word_waddr,
  input  logic [31:0]        word_wdata,
  input  logic               start,
  input  logic [ROUND_W-1:0] cfg_rounds,
  input  logic [BATCH_W-1:0] cfg_batch,
  input  logic [HGT_W-1:0]   cfg_height,
  output logic               busy,
  output logic               done,
  input  logic [WALK_AW-1:0] rd_addr,
  output logic [NODE_AW-1:0] rd_pos,
  output logic [31:0]        rd_word
);
  import tw_pkg::*;

  localparam int NCNT_W = NODE_AW + 1;
  localparam int TAG_W  = WALK_AW + NODE_AW;
  localparam int INF_W  = $clog2(HASH_STAGES + 4);

  walk_st_e           st;
  logic [ROUND_W-1:0] rounds_q, rnd_q;
  logic [BATCH_W-1:0] batch_q;
  logic [HGT_W-1:0]   hgt_q;
  logic [WALK_AW-1:0] wk_q;
  logic               first_q, done_q;
  logic [INF_W-1:0]   inflight_q;
  logic               issue;

  // pipeline registers
  logic               s1_v, s2_v;
  logic [WALK_AW-1:0] s1_w, s2_w;
  logic [NODE_AW-1:0] s2_pos;
  word_t              s2_word;

  // RAM ports
  logic [WALK_AW-1:0] wk_raddr;
  logic [NODE_AW-1:0] pos_rdata, pos_cur;
  word_t              word_rdata, node_rdata;
  logic               wb_v;
  logic [TAG_W-1:0]   wb_tag;
  logic [WALK_AW-1:0] wb_w;
  logic [NODE_AW-1:0] wb_pos, nxt_pos;
  word_t              wb_word;
  logic [NCNT_W-1:0]  nxt_raw, node_cnt;
  logic               wword_we;
  logic [WALK_AW-1:0] wword_addr;
  word_t              wword_data;

  assign busy     = (st != ST_IDLE);
  assign done     = done_q;
  assign issue    = (st == ST_ISSUE);
  assign wk_raddr = busy ? wk_q : rd_addr;
  assign pos_cur  = first_q ? '0 : pos_rdata;

  // ---- control ----
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      done_q  <= 1'b0;
      wk_q    <= '0;
      rnd_q   <= '0;
      first_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          rounds_q <= cfg_rounds;
          batch_q  <= cfg_batch;
          hgt_q    <= cfg_height;
          wk_q     <= '0;
          rnd_q    <= '0;
          first_q  <= 1'b1;
          st <= (cfg_rounds == '0 || cfg_batch == '0) ? ST_FIN : ST_ISSUE;
        end
        ST_ISSUE: begin
          if ({1'b0, wk_q} == batch_q - BATCH_W'(1)) st <= ST_DRAIN;
          else wk_q <= wk_q + 1'b1;
        end
        ST_DRAIN: if (inflight_q == '0) begin
          if (rnd_q == rounds_q - ROUND_W'(1)) st <= ST_FIN;
          else begin
            rnd_q   <= rnd_q + 1'b1;
            wk_q    <= '0;
            first_q <= 1'b0;
            st      <= ST_ISSUE;
          end
        end
        default: begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) inflight_q <= '0;
    else if (issue && !wb_v) inflight_q <= inflight_q + 1'b1;
    else if (!issue && wb_v) inflight_q <= inflight_q - 1'b1;
  end

  // ---- front of pipeline: walker state, then node word ----
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= issue;
      s2_v <= s1_v;
    end
    s1_w    <= wk_q;
    s2_w    <= s1_w;
    s2_pos  <= pos_cur;
    s2_word <= word_rdata;
  end

  tw_ram #(.AW(NODE_AW), .DW(32)) u_node_ram (
    .clk(clk), .we(node_we && !busy), .waddr(node_waddr), .wdata(node_wdata),
    .raddr(pos_cur), .rdata(node_rdata)
  );

  tw_hash_pipe #(.TAG_W(TAG_W)) u_mix (
    .clk(clk), .rst(rst), .in_v(s2_v), .in_tag({s2_w, s2_pos}),
    .in_word(s2_word ^ node_rdata),
    .out_v(wb_v), .out_tag(wb_tag), .out_word(wb_word)
  );

  // ---- write-back: child choice and wrap ----
  assign wb_w     = wb_tag[TAG_W-1:NODE_AW];
  assign wb_pos   = wb_tag[NODE_AW-1:0];
  assign nxt_raw  = {wb_pos, 1'b0} + (wb_word[0] ? NCNT_W'(2) : NCNT_W'(1));
  assign node_cnt = (NCNT_W'(1) << ({1'b0, hgt_q} + 1'b1)) - NCNT_W'(1);
  assign nxt_pos  = (nxt_raw >= node_cnt) ? '0 : nxt_raw[NODE_AW-1:0];

  assign wword_we   = wb_v || (word_we && !busy);
  assign wword_addr = wb_v ? wb_w : word_waddr;
  assign wword_data = wb_v ? wb_word : word_wdata;

  tw_ram #(.AW(WALK_AW), .DW(NODE_AW)) u_pos_ram (
    .clk(clk), .we(wb_v), .waddr(wb_w), .wdata(nxt_pos),
    .raddr(wk_raddr), .rdata(pos_rdata)
  );

  tw_ram #(.AW(WALK_AW), .DW(32)) u_word_ram (
    .clk(clk), .we(wword_we), .waddr(wword_addr), .wdata(wword_data),
    .raddr(wk_raddr), .rdata(word_rdata)
  );

  assign rd_pos  = pos_rdata;
  assign rd_word = word_rdata;
endmodule

// File: rtl/tw_walk_chk.sv
module tw_walk_chk #(
  parameter int WALK_AW = 4,
  parameter int INF_W   = 4,
  parameter int LAT_MAX = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [WALK_AW:0]   cfg_batch,
  input logic               wb_v,
  input logic [WALK_AW-1:0] wb_w,
  input logic [INF_W-1:0]   inflight
);
  logic [WALK_AW-1:0] exp_w;
  logic [WALK_AW:0]   bat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_w <= '0;
      bat_q <= '0;
    end else if (start && !busy) begin
      exp_w <= '0;
      bat_q <= cfg_batch;
    end else if (wb_v) begin
      exp_w <= (({1'b0, wb_w} + (WALK_AW+1)'(1)) == bat_q) ? '0 : wb_w + 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && !done));
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  a_r7_busy_ends_done: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  a_r6_wb_order: assert property (@(posedge clk) disable iff (rst) wb_v |-> (wb_w == exp_w));
  a_r6_inflight_cap: assert property (@(posedge clk) disable iff (rst) inflight <= INF_W'(LAT_MAX));
  a_r9_wb_only_busy: assert property (@(posedge clk) disable iff (rst) wb_v |-> busy);
endmodule

bind tw_walk_top tw_walk_chk #(
  .WALK_AW(WALK_AW), .INF_W(INF_W), .LAT_MAX(tw_pkg::HASH_STAGES + 2)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .cfg_batch(cfg_batch), .wb_v(wb_v), .wb_w(wb_w), .inflight(inflight_q)
);

// File: tb/tw_walk_top_tb.sv
module tw_walk_top_tb;
  localparam int MAX_H   = 5;
  localparam int WALK_AW = 4;
  localparam int ROUND_W = 8;
  localparam int NODE_AW = MAX_H + 1;
  localparam int HGT_W   = $clog2(MAX_H + 1);
  localparam int NWALK   = 1 << WALK_AW;
  localparam int NNODE   = 1 << NODE_AW;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               node_we = 1'b0;
  logic [NODE_AW-1:0] node_waddr = '0;
  logic [31:0]        node_wdata = '0;
  logic               word_we = 1'b0;
  logic [WALK_AW-1:0] word_waddr = '0;
  logic [31:0]        word_wdata = '0;
  logic               start = 1'b0;
  logic [ROUND_W-1:0] cfg_rounds = '0;
  logic [WALK_AW:0]   cfg_batch = '0;
  logic [HGT_W-1:0]   cfg_height = '0;
  logic               busy, done;
  logic [WALK_AW-1:0] rd_addr = '0;
  logic [NODE_AW-1:0] rd_pos;
  logic [31:0]        rd_word;

  tw_walk_top #(.MAX_H(MAX_H), .WALK_AW(WALK_AW), .ROUND_W(ROUND_W)) u_dut (
    .clk(clk), .rst(rst), .node_we(node_we), .node_waddr(node_waddr),
    .node_wdata(node_wdata), .word_we(word_we), .word_waddr(word_waddr),
    .word_wdata(word_wdata), .start(start), .cfg_rounds(cfg_rounds),
    .cfg_batch(cfg_batch), .cfg_height(cfg_height), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_pos(rd_pos), .rd_word(rd_word)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int          walker;
    int          pos;
    logic [31:0] word;
    string       req;
  } exp_item_t;

  exp_item_t   sb[$];
  logic [31:0] m_node [NNODE];
  logic [31:0] m_word [NWALK];
  int          m_pos  [NWALK];

  function automatic logic [31:0] ref_mix(input logic [31:0] a);
    logic [31:0] x = a;
    x = (x + 32'h7ED55D16) + (x << 12);
    x = (x ^ 32'hC761C23C) ^ (x >> 19);
    x = (x + 32'h165667B1) + (x << 5);
    x = (x + 32'hD3A2646C) ^ (x << 9);
    x = (x + 32'hFD7046C5) + (x << 3);
    x = (x ^ 32'hB55A4F09) ^ (x >> 16);
    return x;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic put_node(input int a, input logic [31:0] d);
    node_we = 1'b1; node_waddr = NODE_AW'(a); node_wdata = d;
    @(negedge clk);
    node_we = 1'b0;
    m_node[a] = d;
  endtask

  task automatic put_word(input int a, input logic [31:0] d);
    word_we = 1'b1; word_waddr = WALK_AW'(a); word_wdata = d;
    @(negedge clk);
    word_we = 1'b0;
    m_word[a] = d;
  endtask

  // driver: computes expected walker state and pushes it to the scoreboard
  task automatic drive_run(input int rounds, input int batch, input int h,
                           input bit poke, input string req);
    int cnt = (1 << (h + 1)) - 1;
    int wait_c = 0;
    if (rounds > 0) begin
      for (int w = 0; w < batch; w++) begin
        int p = 0;
        logic [31:0] v = m_word[w];
        for (int r = 0; r < rounds; r++) begin
          v = ref_mix(v ^ m_node[p]);
          p = 2 * p + (v[0] ? 2 : 1);
          if (p >= cnt) p = 0;
        end
        m_pos[w] = p;
        m_word[w] = v;
      end
    end
    for (int w = 0; w < batch; w++) sb.push_back('{w, m_pos[w], m_word[w], req});

    cfg_rounds = ROUND_W'(rounds); cfg_batch = (WALK_AW+1)'(batch);
    cfg_height = HGT_W'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7", "busy after start", busy, 1);
    while (!done && wait_c < 20000) begin
      if (poke && wait_c == 3) begin
        // R9: mid-run writes and restart must be ignored
        node_we = 1'b1; node_waddr = '0; node_wdata = 32'hDEADBEEF;
        word_we = 1'b1; word_waddr = '0; word_wdata = 32'h12345678;
        start = 1'b1; cfg_rounds = 8'd1; cfg_batch = 5'd1;
      end else begin
        node_we = 1'b0; word_we = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      wait_c++;
    end
    node_we = 1'b0; word_we = 1'b0; start = 1'b0;
    check("R7", "done seen", done, 1);
    check("R7", "busy low with done", busy, 0);
    @(negedge clk);
    check("R7", "done one cycle", done, 0);
  endtask

  // monitor: reads each walker back through the read port and pops expectations
  task automatic read_back();
    while (sb.size() > 0) begin
      exp_item_t e = sb.pop_front();
      rd_addr = WALK_AW'(e.walker);
      @(negedge clk);
      check(e.req, $sformatf("walker %0d pos", e.walker), rd_pos, e.pos);
      check(e.req, $sformatf("walker %0d word", e.walker), rd_word, e.word);
    end
  endtask

  initial begin
    logic [31:0] seed = 32'h1357_9BDF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "busy after reset", busy, 0);
    check("R1", "done after reset", done, 0);

    for (int n = 0; n < NNODE; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      put_node(n, {2'b00, seed[31:2]});
    end
    for (int w = 0; w < NWALK; w++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      put_word(w, seed ^ 32'h0F0F_3C3C);
    end

    drive_run(1, 5, 2, 0, "R2_R3");        // single step from root
    read_back();
    drive_run(9, 8, 2, 0, "R4_R5");        // small tree, many wraps
    read_back();
    drive_run(6, 1, 3, 0, "R6");           // one walker, depends on own write-back
    read_back();
    drive_run(0, 4, 3, 0, "R8");           // zero rounds: nothing changes
    read_back();
    for (int w = 0; w < 4; w++) sb.push_back('{w, m_pos[w], m_word[w], "R8"});
    drive_run(3, 0, 3, 0, "R8");           // zero batch: nothing changes
    read_back();
    drive_run(3, 6, 4, 1, "R9");           // mid-run writes and start ignored
    read_back();
    for (int w = 0; w < NWALK; w++) put_word(w, 32'hA5A5_0000 + 32'(w * 977));
    drive_run(20, 16, 5, 0, "R10_R4");     // full tree, full batch
    read_back();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule